// File: doc/BRIEF.md
# Loss-of-Lock Monitor with Hysteresis

This block watches up to four independent PLL channels and flags a loss of lock for each one. Every cycle it receives an unsigned phase-error magnitude per channel. A channel enters loss of lock when its error rises above a programmable set threshold. It may leave loss of lock only when the error falls below a separate, lower clear threshold. The gap between the two thresholds gives hysteresis. A per-channel clear-delay timer can also require the error to stay below the clear threshold for a programmed number of cycles before the flag drops. This timer can be bypassed per channel.

Each channel has a live status bit and a sticky flag bit. The sticky flag records every entry into loss of lock until software writes a zero to it. All configuration and status sit behind a simple byte-wide register port. Writes are synchronous. Reads are combinational from the address.

Register map, by byte address:
- 0x00: live status (read-only)
- 0x01: sticky flags
- 0x02: timer enables
- 0x10 + ch: set threshold
- 0x14 + ch: clear threshold
- 0x20 + 4·ch + byte: 29-bit clear delay, least significant byte first

Top module: `lol_monitor`

## Requirements
- R1: While reset is held, every channel reports loss of lock and the values read back are as follows: status 0x0F, sticky flags 0x0F, timer enables 0x0F, set thresholds 0x80, clear thresholds 0x40, delay 0.
- R2: A channel's sticky flag (address 0x01, bit = channel) sets on every transition into loss of lock. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. If a clearing write and a new transition fall in the same cycle, the flag stays set.
- R3: Loss of lock asserts one cycle after the channel's error is strictly greater than its set threshold. An error equal to the set threshold does not assert it.
- R4: While the error is neither above the set threshold nor below the clear threshold, the channel's status holds its value.
- R5: With the timer enabled (address 0x02, bit = channel, 1 = enabled) and delay D ≥ 1, status deasserts on the clock edge that samples the D-th consecutive cycle of error below the clear threshold. Any cycle at or above the clear threshold restarts the count from zero. A delay of 0 acts like 1.
- R6: With the timer bypassed (enable bit 0), status deasserts one cycle after the error is first sampled below the clear threshold.
- R7: Configuration registers read back what was written. In delay byte 3 only bits [4:0] are stored, and the rest read 0. Writes to the status address (0x00) have no effect.
- R8: If the clear threshold is set above the set threshold, an error above the set threshold still asserts loss of lock and holds it.
- R9: Channels are independent. One channel's error and configuration do not change another channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pll_err_i | input | NCH*THR_W | Per-channel error magnitude, channel 0 in the low byte |
| lol_o | output | NCH | Live loss-of-lock status, one bit per channel |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |

## Verification
The bench drives an error exactly equal to the set threshold. A design that compares with greater-or-equal would assert there.

It interrupts a running clear delay with a single mid-band cycle and checks the status one cycle before and one cycle at the restarted deadline. A counter that pauses instead of restarting would clear early.

It collides a sticky-clear write with a fresh loss-of-lock event. A design that lets the write win would lose the event.

It also writes ones to the sticky register and writes to the read-only status register. A design that toggled flags or accepted the write would change the value read back. Finally, it programs a clear threshold above the set threshold, which catches a design that lets the clear path override the set path.

// File: rtl/lol_monitor.sv
module lol_monitor #(
  parameter int NCH   = 4,
  parameter int THR_W = 8,
  parameter int DLY_W = 29
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH*THR_W-1:0] pll_err_i,
  output logic [NCH-1:0]       lol_o,
  input  logic                 reg_we_i,
  input  logic [7:0]           reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o
);
  localparam int DB = (DLY_W + 7) / 8;
  localparam int DW = DB * 8;
  localparam logic [DW-1:0] DMASK = DW'((64'd1 << DLY_W) - 64'd1);
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_FLG  = 8'h01;
  localparam logic [7:0] A_TEN  = 8'h02;
  localparam logic [7:0] A_SET  = 8'h10;
  localparam logic [7:0] A_CLR  = 8'h14;
  localparam logic [7:0] A_DLY  = 8'h20;

  logic [NCH-1:0][THR_W-1:0] set_q, clr_q;
  logic [NCH-1:0][DW-1:0]    dly_q, cnt_q;
  logic [NCH-1:0]            lol_q, flg_q, ten_q, hit, below, rise;

  assign lol_o = lol_q;
  assign rise  = hit & ~lol_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [THR_W-1:0] e;
    logic [DW-1:0]    cnt_nx;
    assign e        = pll_err_i[c*THR_W +: THR_W];
    assign hit[c]   = e > set_q[c];
    assign below[c] = e < clr_q[c];
    assign cnt_nx   = cnt_q[c] + DW'(1);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lol_q[c] <= 1'b1;
        cnt_q[c] <= '0;
      end else if (hit[c]) begin
        lol_q[c] <= 1'b1;
        cnt_q[c] <= '0;
      end else if (lol_q[c] && below[c]) begin
        if (!ten_q[c] || cnt_nx >= dly_q[c]) begin
          lol_q[c] <= 1'b0;
          cnt_q[c] <= '0;
        end else begin
          cnt_q[c] <= cnt_nx;
        end
      end else begin
        cnt_q[c] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_q <= '1;
      ten_q <= '1;
      for (int c = 0; c < NCH; c++) begin
        set_q[c] <= THR_W'(8'h80);
        clr_q[c] <= THR_W'(8'h40);
        dly_q[c] <= '0;
      end
    end else begin
      if (reg_we_i && reg_addr_i == A_FLG)
        flg_q <= (flg_q & reg_wdata_i[NCH-1:0]) | rise;
      else
        flg_q <= flg_q | rise;
      if (reg_we_i && reg_addr_i == A_TEN) ten_q <= reg_wdata_i[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (reg_we_i && reg_addr_i == A_SET + 8'(c)) set_q[c] <= reg_wdata_i[THR_W-1:0];
        if (reg_we_i && reg_addr_i == A_CLR + 8'(c)) clr_q[c] <= reg_wdata_i[THR_W-1:0];
        for (int b = 0; b < DB; b++)
          if (reg_we_i && reg_addr_i == A_DLY + 8'(c*4 + b))
            dly_q[c][b*8 +: 8] <= reg_wdata_i & DMASK[b*8 +: 8];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_STAT) reg_rdata_o[NCH-1:0] = lol_q;
    if (reg_addr_i == A_FLG)  reg_rdata_o[NCH-1:0] = flg_q;
    if (reg_addr_i == A_TEN)  reg_rdata_o[NCH-1:0] = ten_q;
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr_i == A_SET + 8'(c)) reg_rdata_o[THR_W-1:0] = set_q[c];
      if (reg_addr_i == A_CLR + 8'(c)) reg_rdata_o[THR_W-1:0] = clr_q[c];
      for (int b = 0; b < DB; b++)
        if (reg_addr_i == A_DLY + 8'(c*4 + b)) reg_rdata_o = dly_q[c][b*8 +: 8];
    end
  end
endmodule

// File: rtl/lol_monitor_chk.sv
module lol_monitor_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] lol,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] below,
  input logic [NCH-1:0] ten,
  input logic [NCH-1:0] flg
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    p_assert_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit[c] |=> lol[c]);
    p_hold_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit[c] && !below[c]) |=> $stable(lol[c]));
    p_bypass_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lol[c] && !hit[c] && below[c] && !ten[c]) |=> !lol[c]);
    p_fall_needs_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lol[c]) |-> $past(below[c]));
    p_rise_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lol[c]) |-> flg[c]);
  end
endmodule

bind lol_monitor lol_monitor_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .lol(lol_q), .hit(hit),
  .below(below), .ten(ten_q), .flg(flg_q)
);

// File: tb/lol_monitor_tb_top.sv
`timescale 1ns/1ps
module lol_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] e [4];
  logic [31:0] err;
  logic [3:0] lol;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { bit rd; logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  assign err = {e[3], e[2], e[1], e[0]};

  lol_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .pll_err_i(err), .lol_o(lol),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_lol(logic [3:0] exp, string tag);
    q.push_back('{1'b0, {4'h0, exp}, tag});
  endtask

  task automatic expect_rd(logic [7:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a;
    q.push_back('{1'b1, exp, tag});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin : monitor
    item_t it;
    logic [7:0] act;
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        it = q.pop_front();
        act = it.rd ? rdata : {4'h0, lol};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 4; i++) e[i] = 8'h50;
    tick(2);
    expect_lol(4'hF, "R1 status in reset");
    expect_rd(8'h00, 8'h0F, "R1 status reg");
    expect_rd(8'h01, 8'h0F, "R1 sticky reg");
    expect_rd(8'h02, 8'h0F, "R1 timer enables");
    expect_rd(8'h10, 8'h80, "R1 set thr");
    expect_rd(8'h14, 8'h40, "R1 clr thr");
    expect_rd(8'h20, 8'h00, "R1 delay");
    @(negedge clk); rst_n = 1'b1;
    tick(3);
    expect_lol(4'hF, "R4 mid-band hold");

    wr(8'h01, 8'h00);
    expect_rd(8'h01, 8'h00, "R2 write zero clears");
    wr(8'h00, 8'h00);
    expect_lol(4'hF, "R7 status write ignored");
    expect_rd(8'h00, 8'h0F, "R7 status reg unchanged");
    wr(8'h23, 8'hFF);
    expect_rd(8'h23, 8'h1F, "R7 delay top byte masked");
    wr(8'h23, 8'h00);
    wr(8'h20, 8'h05);
    expect_rd(8'h20, 8'h05, "R7 delay readback");
    wr(8'h02, 8'h0D);
    expect_rd(8'h02, 8'h0D, "R7 timer enable readback");

    @(negedge clk); e[1] = 8'h10;
    @(negedge clk);
    expect_lol(4'hD, "R6 bypass clears, R9 others held");

    @(negedge clk); e[0] = 8'h10;
    tick(4);
    expect_lol(4'hD, "R5 before delay expires");
    tick(1);
    expect_lol(4'hC, "R5 at delay expiry");

    @(negedge clk); e[0] = 8'h80;
    tick(2);
    expect_lol(4'hC, "R3 equal to threshold no assert");
    @(negedge clk); e[0] = 8'h81;
    @(negedge clk);
    expect_lol(4'hD, "R3 above threshold asserts");
    expect_rd(8'h01, 8'h01, "R2 event sets flag");

    @(negedge clk); e[0] = 8'h10;
    tick(3);
    e[0] = 8'h60;
    tick(1);
    e[0] = 8'h10;
    tick(4);
    expect_lol(4'hD, "R5 restart after interruption");
    tick(1);
    expect_lol(4'hC, "R5 clear after restarted delay");

    wr(8'h01, 8'hFF);
    expect_rd(8'h01, 8'h01, "R2 write one keeps flags");
    wr(8'h01, 8'h00);
    expect_rd(8'h01, 8'h00, "R2 clear flag");

    @(negedge clk);
    e[0] = 8'h90; we = 1'b1; addr = 8'h01; wdata = 8'h00;
    @(negedge clk);
    we = 1'b0;
    expect_lol(4'hD, "R3 collision assert");
    expect_rd(8'h01, 8'h01, "R2 event wins over clear");

    wr(8'h16, 8'h90);
    tick(1);
    expect_lol(4'h9, "R9 ch2 clears independently");
    @(negedge clk); e[2] = 8'h85;
    @(negedge clk);
    expect_lol(4'hD, "R8 set priority over clear");
    tick(2);
    expect_lol(4'hD, "R8 set priority holds");

    tick(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule